// File: doc/BRIEF.md
# Serial Flash Boot Fetcher with Address-Width Probing

This block reads a boot image out of a serial EEPROM or flash over SPI when the memory's address length is not known in advance. A one-cycle `start` pulse lowers the single chip select and sends the read opcode. The block then sends zero-valued address bytes one at a time. After each address byte it exchanges one probe byte. The first probe that does not return 0xFF shows that the memory has started returning data. The number of address bytes sent up to that point is the detected address width.

The probe byte that hit is the first byte of the image. The block delivers it, and the remaining bytes of the requested length, on a valid/ready byte stream. While the consumer stalls, the serial clock stops, and chip select stays low for the whole transaction. An unpopulated socket reads back as all ones because the data-in line has a pull-up. If that happens for every permitted address length, the block reports an error and releases the memory.

The control FSM has six states: `ST_IDLE`, `ST_CMD`, `ST_ADDR`, `ST_PROBE`, `ST_STREAM` and `ST_HOLD`. Its transitions are:
- `ST_IDLE` to `ST_CMD` on `start`.
- `ST_CMD` to `ST_ADDR` when the opcode byte completes.
- `ST_ADDR` to `ST_PROBE` when an address byte completes.
- `ST_PROBE` to `ST_HOLD` on a non-0xFF probe.
- `ST_PROBE` to `ST_ADDR` on 0xFF while fewer than four address bytes have been sent.
- `ST_PROBE` to `ST_IDLE` on 0xFF after the fourth address byte (error).
- `ST_STREAM` to `ST_HOLD` when a data byte completes.
- `ST_HOLD` to `ST_STREAM` when a byte is accepted and more remain.
- `ST_HOLD` to `ST_IDLE` when the last byte is accepted (done).

Top module: `spi_boot_probe`

## Requirements
- R1: After reset: `spi_cs_n`=1, `spi_sck`=0, `out_valid`=0, `done`=0, `error`=0, `width_code`=0.
- R2: On `start`, `spi_cs_n` goes low and the first byte on `spi_mosi` is the read opcode 0x03. Transfers are SPI mode 0 and MSB first: SCK idles low, and the device samples MOSI on the rising SCK edge.
- R3: Every byte sent after the opcode is 0x00. Address bytes and probe bytes alternate, up to four address bytes.
- R4: The first probe byte not equal to 0xFF is the first byte delivered on `out_data`. `width_code` then equals the number of address bytes sent minus one (0 to 3 means 1 to 4 bytes).
- R5: If four probes all return 0xFF, then `error`=1, `done`=0, `spi_cs_n` returns high, no byte is delivered, and exactly 9 bytes were clocked in total.
- R6: Exactly `len_in` bytes, sampled at `start`, are delivered in memory order, with a length of 0 treated as 1. A byte transfers when `out_valid` and `out_ready` are both high. While `out_valid` is high and `out_ready` is low, `out_data` holds and `spi_sck` stays low.
- R7: After the last byte is accepted, `done`=1 and `spi_cs_n`=1. Chip select falls exactly once per transaction.
- R8: The SCK period is 2×D system clocks, where D is the divider. D is 0x85 after reset and is reloaded from `div_in` by `div_load` while idle. D=0 behaves as D=1.
- R9: A `start` pulse while a transaction is in progress has no effect on the bytes clocked or delivered.
- R10: `spi_sck` is low whenever `spi_cs_n` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | One-cycle pulse that begins a fetch while idle |
| len_in | input | 16 | Number of image bytes to deliver, sampled at start |
| div_load | input | 1 | Loads `div_in` into the SCK divider while idle |
| div_in | input | 8 | New SCK half-period in system clocks |
| spi_sck | output | 1 | Serial clock, idle low |
| spi_mosi | output | 1 | Serial data to memory |
| spi_miso | input | 1 | Serial data from memory (pulled up externally) |
| spi_cs_n | output | 1 | Active-low chip select |
| out_data | output | 8 | Delivered image byte |
| out_valid | output | 1 | `out_data` holds a byte |
| out_ready | input | 1 | Consumer accepts the byte |
| width_code | output | 2 | Detected address bytes minus one |
| done | output | 1 | Fetch completed; held until next start |
| error | output | 1 | No device answered; held until next start |

## Verification
The assertions check the following on every cycle:
- SCK never moves while chip select is high.
- A stalled output byte holds its value and keeps SCK parked.
- `done` and `error` are never high together.
- Either flag implies chip select is released.

Only the bench scenarios can show the byte-level protocol. That covers the opcode and the zero address/probe pattern, the detected width for each of the four memory sizes, image order and length, the absent-device path, the measured SCK period for the default, loaded and zero divider, and the disregard of a repeated start.

// File: rtl/spi_boot_pkg.sv
package spi_boot_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_CMD,
        ST_ADDR,
        ST_PROBE,
        ST_STREAM,
        ST_HOLD
    } boot_state_t;

    localparam logic [7:0] BLANK_BYTE = 8'hFF;
    localparam logic [7:0] ZERO_BYTE  = 8'h00;

endpackage

// File: rtl/spi_half_timer.sv
module spi_half_timer #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [DIV_W-1:0] div,
    output logic             tick
);
    localparam logic [DIV_W-1:0] ONE = DIV_W'(1);

    logic [DIV_W-1:0] cnt_q;
    logic [DIV_W-1:0] limit;

    // a zero divider behaves as one
    assign limit = (div == '0) ? ONE : div;
    assign tick  = run && (cnt_q == (limit - ONE));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (!run || tick) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + ONE;
        end
    end
endmodule

// File: rtl/spi_byte_xfer.sv
module spi_byte_xfer #(
    parameter int DIV_W  = 8,
    parameter int BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DIV_W-1:0]  div,
    input  logic              go,
    input  logic [BYTE_W-1:0] tx_byte,
    input  logic              miso,
    output logic              sck,
    output logic              mosi,
    output logic [BYTE_W-1:0] rx_byte,
    output logic              done
);
    localparam int BIT_W = $clog2(BYTE_W);
    localparam logic [BIT_W-1:0] LAST_BIT = BIT_W'(BYTE_W - 1);
    localparam logic [BIT_W-1:0] BIT_ONE  = BIT_W'(1);

    logic              busy_q;
    logic              sck_q;
    logic              done_q;
    logic [BIT_W-1:0]  bit_q;
    logic [BYTE_W-1:0] tx_sr;
    logic [BYTE_W-1:0] rx_sr;
    logic              tick;

    spi_half_timer #(.DIV_W(DIV_W)) u_timer (
        .clk  (clk),
        .rst_n(rst_n),
        .run  (busy_q),
        .div  (div),
        .tick (tick)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            busy_q <= 1'b0;
            sck_q  <= 1'b0;
            done_q <= 1'b0;
            bit_q  <= '0;
            tx_sr  <= '0;
            rx_sr  <= '0;
        end else begin
            done_q <= 1'b0;
            if (go && !busy_q) begin
                busy_q <= 1'b1;
                tx_sr  <= tx_byte;
                bit_q  <= '0;
                sck_q  <= 1'b0;
            end else if (tick) begin
                if (!sck_q) begin
                    // rising edge: capture MISO
                    sck_q <= 1'b1;
                    rx_sr <= {rx_sr[BYTE_W-2:0], miso};
                end else begin
                    // falling edge: advance MOSI or finish
                    sck_q <= 1'b0;
                    if (bit_q == LAST_BIT) begin
                        busy_q <= 1'b0;
                        done_q <= 1'b1;
                    end else begin
                        bit_q <= bit_q + BIT_ONE;
                        tx_sr <= {tx_sr[BYTE_W-2:0], 1'b0};
                    end
                end
            end
        end
    end

    assign sck     = sck_q;
    assign mosi    = busy_q & tx_sr[BYTE_W-1];
    assign rx_byte = rx_sr;
    assign done    = done_q;
endmodule

// File: rtl/spi_boot_probe.sv
module spi_boot_probe
    import spi_boot_pkg::*;
#(
    parameter int               DIV_W          = 8,
    parameter logic [DIV_W-1:0] DEFAULT_DIV    = DIV_W'(8'h85),
    parameter logic [7:0]       READ_OPCODE    = 8'h03,
    parameter int               MAX_ADDR_BYTES = 4,
    parameter int               LEN_W          = 16,
    localparam int              CODE_W         = (MAX_ADDR_BYTES > 1) ? $clog2(MAX_ADDR_BYTES) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [LEN_W-1:0]  len_in,
    input  logic              div_load,
    input  logic [DIV_W-1:0]  div_in,
    output logic              spi_sck,
    output logic              spi_mosi,
    input  logic              spi_miso,
    output logic              spi_cs_n,
    output logic [7:0]        out_data,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [CODE_W-1:0] width_code,
    output logic              done,
    output logic              error
);
    localparam int NADDR_W = $clog2(MAX_ADDR_BYTES + 1);
    localparam logic [NADDR_W-1:0] NADDR_ONE = NADDR_W'(1);
    localparam logic [NADDR_W-1:0] NADDR_MAX = NADDR_W'(MAX_ADDR_BYTES);
    localparam logic [LEN_W-1:0]   LEN_ONE   = LEN_W'(1);

    boot_state_t state_q, state_d;

    logic [DIV_W-1:0]   div_q;
    logic [LEN_W-1:0]   len_q;
    logic [LEN_W-1:0]   sent_q;
    logic [NADDR_W-1:0] naddr_q;
    logic [CODE_W-1:0]  code_q;
    logic [7:0]         data_q;
    logic [7:0]         tx_q;
    logic               go_q;
    logic               done_q;
    logic               err_q;

    logic [7:0] rx_byte;
    logic       xfer_done;
    logic       probe_hit;
    logic       last_byte;

    spi_byte_xfer #(.DIV_W(DIV_W), .BYTE_W(8)) u_xfer (
        .clk    (clk),
        .rst_n  (rst_n),
        .div    (div_q),
        .go     (go_q),
        .tx_byte(tx_q),
        .miso   (spi_miso),
        .sck    (spi_sck),
        .mosi   (spi_mosi),
        .rx_byte(rx_byte),
        .done   (xfer_done)
    );

    assign probe_hit = (rx_byte != BLANK_BYTE);
    assign last_byte = ((sent_q + LEN_ONE) == len_q);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (start) state_d = ST_CMD;
            ST_CMD:    if (xfer_done) state_d = ST_ADDR;
            ST_ADDR:   if (xfer_done) state_d = ST_PROBE;
            ST_PROBE: begin
                if (xfer_done) begin
                    if (probe_hit)                 state_d = ST_HOLD;
                    else if (naddr_q == NADDR_MAX) state_d = ST_IDLE;
                    else                           state_d = ST_ADDR;
                end
            end
            ST_STREAM: if (xfer_done) state_d = ST_HOLD;
            ST_HOLD: begin
                if (out_ready) state_d = last_byte ? ST_IDLE : ST_STREAM;
            end
            default:   state_d = ST_IDLE;
        endcase
    end

    // datapath registers updated on transitions
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            div_q   <= DEFAULT_DIV;
            len_q   <= '0;
            sent_q  <= '0;
            naddr_q <= '0;
            code_q  <= '0;
            data_q  <= '0;
            tx_q    <= '0;
            go_q    <= 1'b0;
            done_q  <= 1'b0;
            err_q   <= 1'b0;
        end else begin
            go_q <= 1'b0;
            unique case (state_q)
                ST_IDLE: begin
                    if (div_load) div_q <= div_in;
                    if (start) begin
                        len_q   <= (len_in == '0) ? LEN_ONE : len_in;
                        sent_q  <= '0;
                        naddr_q <= '0;
                        code_q  <= '0;
                        done_q  <= 1'b0;
                        err_q   <= 1'b0;
                        tx_q    <= READ_OPCODE;
                        go_q    <= 1'b1;
                    end
                end
                ST_CMD: begin
                    if (xfer_done) begin
                        naddr_q <= NADDR_ONE;
                        tx_q    <= ZERO_BYTE;
                        go_q    <= 1'b1;
                    end
                end
                ST_ADDR: begin
                    if (xfer_done) begin
                        tx_q <= ZERO_BYTE;
                        go_q <= 1'b1;
                    end
                end
                ST_PROBE: begin
                    if (xfer_done) begin
                        if (probe_hit) begin
                            data_q <= rx_byte;
                            code_q <= CODE_W'(naddr_q - NADDR_ONE);
                        end else if (naddr_q == NADDR_MAX) begin
                            err_q <= 1'b1;
                        end else begin
                            naddr_q <= naddr_q + NADDR_ONE;
                            tx_q    <= ZERO_BYTE;
                            go_q    <= 1'b1;
                        end
                    end
                end
                ST_STREAM: begin
                    if (xfer_done) data_q <= rx_byte;
                end
                ST_HOLD: begin
                    if (out_ready) begin
                        sent_q <= sent_q + LEN_ONE;
                        if (last_byte) begin
                            done_q <= 1'b1;
                        end else begin
                            tx_q <= ZERO_BYTE;
                            go_q <= 1'b1;
                        end
                    end
                end
                default: ;
            endcase
        end
    end

    // outputs
    always_comb begin
        spi_cs_n   = (state_q == ST_IDLE);
        out_valid  = (state_q == ST_HOLD);
        out_data   = data_q;
        width_code = code_q;
        done       = done_q;
        error      = err_q;
    end
endmodule

// File: rtl/spi_boot_probe_chk.sv
module spi_boot_probe_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       spi_sck,
    input logic       spi_cs_n,
    input logic [7:0] out_data,
    input logic       out_valid,
    input logic       out_ready,
    input logic       done,
    input logic       error
);
    a_r10_sck_parked_deselected: assert property (@(posedge clk) disable iff (!rst_n)
        spi_cs_n |-> !spi_sck);

    a_r6_stall_holds_byte: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

    a_r6_stall_stops_sck: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> !spi_sck);

    a_r5_flags_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(done && error));

    a_r7_flag_releases_cs: assert property (@(posedge clk) disable iff (!rst_n)
        (done || error) |-> spi_cs_n);
endmodule

bind spi_boot_probe spi_boot_probe_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .spi_sck  (spi_sck),
    .spi_cs_n (spi_cs_n),
    .out_data (out_data),
    .out_valid(out_valid),
    .out_ready(out_ready),
    .done     (done),
    .error    (error)
);

// File: tb/spi_boot_probe_bench.sv
`timescale 1ns/100ps
module spi_boot_probe_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [15:0] len_in = '0;
    logic        div_load = 1'b0;
    logic [7:0]  div_in = '0;
    logic        spi_sck, spi_mosi, spi_miso, spi_cs_n;
    logic [7:0]  out_data;
    logic        out_valid;
    logic        out_ready = 1'b0;
    logic [1:0]  width_code;
    logic        done, error;

    always #2.5 clk = ~clk;

    spi_boot_probe u_spi_boot_probe (
        .clk(clk), .rst_n(rst_n), .start(start), .len_in(len_in),
        .div_load(div_load), .div_in(div_in),
        .spi_sck(spi_sck), .spi_mosi(spi_mosi), .spi_miso(spi_miso), .spi_cs_n(spi_cs_n),
        .out_data(out_data), .out_valid(out_valid), .out_ready(out_ready),
        .width_code(width_code), .done(done), .error(error)
    );

    int checks = 0;
    int errors = 0;
    int cyc = 0;

    task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 190000) begin
            errors++;
            checks++;
            $display("FAIL watchdog R7 actual=%0d expected=%0d", cyc, 190000);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    // ---------------- memory model ----------------
    int         dev_w = 0;          // address bytes; 0 = absent
    logic [7:0] image [0:63];
    int         kcnt, bitcnt, mosi_n, cs_falls, r1, r2;
    logic [7:0] txsr = 8'hFF;
    logic [7:0] mosi_sr;
    logic [7:0] mosi_log [0:127];
    logic       prev_cs = 1'b1;
    logic       prev_sck = 1'b0;

    function automatic logic [7:0] resp(input int k);
        if (dev_w == 0 || k < 2 * dev_w) return 8'hFF;
        return image[(k - 2 * dev_w) % 64];
    endfunction

    assign spi_miso = spi_cs_n ? 1'b1 : txsr[7];

    always @(spi_sck or spi_cs_n) begin
        if (spi_cs_n !== prev_cs) begin
            if (!spi_cs_n) begin
                kcnt = 0; bitcnt = 0; mosi_n = 0; cs_falls++;
                txsr = resp(0);
            end
            prev_cs = spi_cs_n;
        end
        if (spi_sck !== prev_sck) begin
            if (!spi_cs_n) begin
                if (spi_sck) begin
                    if (kcnt == 0 && bitcnt == 0) r1 = cyc;
                    if (kcnt == 0 && bitcnt == 1) r2 = cyc;
                    mosi_sr = {mosi_sr[6:0], spi_mosi};
                    bitcnt++;
                    if (bitcnt == 8) begin
                        bitcnt = 0;
                        if (mosi_n < 128) mosi_log[mosi_n] = mosi_sr;
                        mosi_n++;
                        kcnt++;
                        txsr = resp(kcnt);
                    end
                end else if (bitcnt != 0) begin
                    txsr = {txsr[6:0], 1'b1};
                end
            end
            prev_sck = spi_sck;
        end
    end

    // ---------------- consumer and R10 monitor ----------------
    bit         stall = 1'b0;
    logic [7:0] got [0:63];
    int         got_n = 0;
    int         r10_viol = 0;

    always @(negedge clk) begin
        if (stall) out_ready = 1'b0;
        else       out_ready = (($urandom % 4) != 0);
        if (out_valid && out_ready) begin
            if (got_n < 64) got[got_n] = out_data;
            got_n++;
        end
        if (rst_n && spi_cs_n && spi_sck) r10_viol++;
    end

    int cur_div = 8'h85;

    task automatic run_txn(input int w, input int len, input int dv, input bit set_div,
                           input bit stall_test, input bit extra_start);
        int len_eff, exp_bytes, exp_half, falls0, n;
        logic [7:0] d0;
        bit sck_moved, data_moved, valid_dropped;
        for (int i = 0; i < 64; i++) image[i] = 8'($urandom);
        if (image[0] == 8'hFF) image[0] = 8'h5A;
        dev_w = w;
        got_n = 0;
        falls0 = cs_falls;
        @(negedge clk);
        if (set_div) begin
            div_load = 1'b1; div_in = 8'(dv); cur_div = dv;
            @(negedge clk);
            div_load = 1'b0;
        end
        len_in = 16'(len);
        stall = stall_test;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        if (extra_start) begin
            repeat (60) @(negedge clk);
            start = 1'b1; len_in = 16'(len + 7);
            @(negedge clk);
            start = 1'b0;
        end
        if (stall_test) begin
            n = 0;
            while (!out_valid && !error && n < 20000) begin @(negedge clk); n++; end
            d0 = out_data;
            sck_moved = 0; data_moved = 0; valid_dropped = 0;
            repeat (40) begin
                @(negedge clk);
                if (spi_sck) sck_moved = 1;
                if (out_data !== d0) data_moved = 1;
                if (!out_valid) valid_dropped = 1;
            end
            chk(!sck_moved, "R6", "sck idle during stall", int'(sck_moved), 0);
            chk(!data_moved && !valid_dropped, "R6", "byte held during stall", int'(data_moved), 0);
            stall = 1'b0;
        end
        n = 0;
        while (!(done || error) && n < 20000) begin @(negedge clk); n++; end
        @(negedge clk);

        len_eff   = (len == 0) ? 1 : len;
        exp_bytes = (w == 0) ? 9 : 2 * w + len_eff;
        exp_half  = (cur_div == 0) ? 1 : cur_div;
        chk(mosi_log[0] == 8'h03, "R2", "opcode on MOSI", int'(mosi_log[0]), 3);
        for (int i = 1; i < exp_bytes && i < 128; i++)
            chk(mosi_log[i] == 8'h00, "R3", "zero byte on MOSI", int'(mosi_log[i]), 0);
        chk(mosi_n == exp_bytes, (w == 0) ? "R5" : "R9", "bytes clocked", mosi_n, exp_bytes);
        chk(r2 - r1 == 2 * exp_half, "R8", "SCK period", r2 - r1, 2 * exp_half);
        chk(cs_falls - falls0 == 1, "R7", "chip-select falls", cs_falls - falls0, 1);
        chk(spi_cs_n == 1'b1, "R7", "cs released at end", int'(spi_cs_n), 1);
        if (w == 0) begin
            chk(error == 1'b1 && done == 1'b0, "R5", "error flag", int'(error), 1);
            chk(got_n == 0, "R5", "no bytes delivered", got_n, 0);
        end else begin
            chk(done == 1'b1 && error == 1'b0, "R7", "done flag", int'(done), 1);
            chk(int'(width_code) == w - 1, "R4", "width code", int'(width_code), w - 1);
            chk(got_n == len_eff, "R6", "delivered count", got_n, len_eff);
            chk(got[0] == image[0], "R4", "first byte is probe hit", int'(got[0]), int'(image[0]));
            for (int i = 1; i < len_eff && i < got_n && i < 64; i++)
                chk(got[i] == image[i], "R6", "image byte", int'(got[i]), int'(image[i]));
        end
    endtask

    initial begin
        void'($urandom(32'd4242));
        repeat (3) @(negedge clk);
        chk(spi_cs_n == 1'b1, "R1", "reset cs_n", int'(spi_cs_n), 1);
        chk(spi_sck == 1'b0 && out_valid == 1'b0, "R1", "reset sck/valid", int'(spi_sck), 0);
        chk(done == 1'b0 && error == 1'b0 && width_code == 2'd0, "R1", "reset flags", int'(done), 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        run_txn(1, 2, 0, 0, 0, 0);      // R8 default divider
        run_txn(2, 3, 0, 1, 0, 0);      // R8 zero divider acts as one
        run_txn(4, 4, 2, 1, 0, 0);      // widest address
        run_txn(3, 5, 3, 1, 0, 0);
        run_txn(0, 4, 2, 1, 0, 0);      // R5 absent device
        run_txn(3, 3, 2, 1, 1, 0);      // R6 stall
        run_txn(2, 4, 2, 1, 0, 1);      // R9 start while busy
        run_txn(1, 0, 1, 1, 0, 0);      // R6 length zero
        for (int t = 0; t < 14; t++) begin
            int w;
            w = ($urandom % 9 == 0) ? 0 : 1 + int'($urandom % 4);
            run_txn(w, 1 + int'($urandom % 12), 1 + int'($urandom % 4), 1, 0, 0);
        end
        chk(r10_viol == 0, "R10", "sck moved while deselected", r10_viol, 0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule